// File: doc/BRIEF.md
# Upset-Detecting One-Hot Sequencer

This block is a small control sequencer that walks through four states in a fixed ring and holds exactly one state bit high at a time. An advance input moves it one step per clock while held high. Each cycle a purely combinational test checks whether the stored pattern has exactly one bit set. If a particle strike or any other disturbance leaves the register with no bits or several bits set, the sequencer leaves normal operation. It drops to a parking pattern and raises a sticky error flag. Recovery logic elsewhere can use that flag, for instance to trigger a reset.

Every one of the sixteen register values has a defined successor, so the recovery path does not depend on a default branch that could be optimized away. Because the encoding is one-hot, a single flipped bit in any legal state always gives an unmapped pattern. Moving silently to another legal state takes two flips at once. A test port XORs a mask into the state register so that upsets can be injected on purpose.

Top module: `ohfsm_guard`

## Requirements
- R1: While `rst_n` is low, and after it is released, `state_o` is 4'b0001 (state S0) and `err_o` is 0.
- R2: In fault-free operation `state_o` has exactly one bit set. Bit i is high in state Si, so S0=0001, S1=0010, S2=0100 and S3=1000.
- R3: When the sequencer is in a legal state with `err_o` low, `advance` high and `flip_en` low, it takes one step per rising clock edge around the ring S0, S1, S2, S3 and back to S0.
- R4: When the sequencer is in a legal state with `advance` low and `flip_en` low, `state_o` is unchanged at the next edge.
- R5: Any stored pattern that does not have exactly one bit set is illegal, including 0000 and multi-bit values such as 0101. At the next edge without injection, the sequencer enters the default state, where `state_o` is 4'b0000 and `err_o` is 1.
- R6: Once `err_o` is set, it stays 1 until reset. The state returns to the parking pattern 0000 at every edge without injection, whatever the value of `advance`, even if an injection has left a one-hot pattern in the register.
- R7: Flipping any single bit of any legal state produces a pattern that is flagged at the next edge.
- R8: When `flip_en` is high at an edge, the register loads its current value XOR `flip_mask`. `advance` is ignored in that cycle and `err_o` holds its value.
- R9: An injection that flips two bits and so moves one legal state to another is not detected. `err_o` stays 0 and sequencing continues from the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| advance | input | 1 | Step to the next state in the ring while high |
| flip_en | input | 1 | Test: XOR `flip_mask` into the state register at this edge |
| flip_mask | input | 4 | Test: bits to invert in the state register |
| state_o | output | 4 | Current state register value (one-hot when healthy) |
| err_o | output | 1 | Sticky upset indicator |

## Verification
A corrupted state register is visible on `state_o` in the same cycle it occurs, because the output is the register itself. One clock later it appears as `state_o` = 0000 together with `err_o` = 1. The bench therefore samples both ports once right after an injection and again one edge later. The one case that gives no symptom at the ports is a double flip onto another legal state: the ring simply continues from the wrong position. The bench checks this case explicitly so that this documented limit stays fixed.

// File: rtl/ohfsm_pkg.sv
package ohfsm_pkg;
  // default number of states in the ring (one register bit per state)
  localparam int unsigned NST_DEF = 4;
endpackage

// File: rtl/ohfsm_valid.sv
// Combinational one-hot validity test: exactly one bit set.
module ohfsm_valid #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] st,
  output logic         ok
);
  logic [N-1:0] low_cleared;
  logic         nonzero;

  assign nonzero     = |st;
  assign low_cleared = st & (st - {{(N-1){1'b0}}, 1'b1});
  assign ok          = nonzero & ~(|low_cleared);
endmodule

// File: rtl/ohfsm_next.sv
// Next-state logic defined for every register value.
module ohfsm_next #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] st,
  input  logic         err_q,
  input  logic         ok,
  input  logic         adv,
  output logic [N-1:0] nst,
  output logic         nerr
);
  logic [N-1:0] rot;

  // ring step: bit i takes bit i-1, bit 0 takes the top bit
  for (genvar i = 0; i < N; i++) begin : g_rot
    if (i == 0) begin : g_wrap
      assign rot[i] = st[N-1];
    end else begin : g_shift
      assign rot[i] = st[i-1];
    end
  end

  always_comb begin
    if (err_q || !ok) begin
      nst  = '0;
      nerr = 1'b1;
    end else begin
      nst  = adv ? rot : st;
      nerr = 1'b0;
    end
  end
endmodule

// File: rtl/ohfsm_reg.sv
// State and error registers with a test path for upset injection.
module ohfsm_reg #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flip_en,
  input  logic [N-1:0] flip_mask,
  input  logic [N-1:0] nst,
  input  logic         nerr,
  output logic [N-1:0] st_q,
  output logic         err_q
);
  localparam logic [N-1:0] RST_ST = {{(N-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RST_ST;
      err_q <= 1'b0;
    end else if (flip_en) begin
      st_q  <= st_q ^ flip_mask;
      err_q <= err_q;
    end else begin
      st_q  <= nst;
      err_q <= nerr;
    end
  end
endmodule

// File: rtl/ohfsm_guard.sv
module ohfsm_guard #(
  parameter int unsigned N = ohfsm_pkg::NST_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic         flip_en,
  input  logic [N-1:0] flip_mask,
  output logic [N-1:0] state_o,
  output logic         err_o
);
  logic [N-1:0] st_q, nst;
  logic         err_q, nerr, ok;

  ohfsm_valid #(.N(N)) u_valid (.st(st_q), .ok(ok));

  ohfsm_next #(.N(N)) u_next (
    .st(st_q), .err_q(err_q), .ok(ok), .adv(advance),
    .nst(nst), .nerr(nerr)
  );

  ohfsm_reg #(.N(N)) u_reg (
    .clk(clk), .rst_n(rst_n), .flip_en(flip_en), .flip_mask(flip_mask),
    .nst(nst), .nerr(nerr), .st_q(st_q), .err_q(err_q)
  );

  assign state_o = st_q;
  assign err_o   = err_q;

  // R3: a healthy step moves the single bit one place up the ring
  p_ring_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_o && ok && !flip_en && advance) |=>
      ($onehot(state_o) &&
       ((state_o == ($past(state_o) << 1)) ||
        (state_o[0] && $past(state_o[N-1])))));

  // R4: no advance, no change
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_o && ok && !flip_en && !advance) |=> $stable(state_o));

  // R2: a legal state without injection stays one-hot
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_o && ok && !flip_en) |=> $onehot(state_o));

  // R5: illegal pattern lands in the default state
  p_illegal_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ok && !flip_en) |=> (state_o == '0 && err_o));

  // R6: error flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R8: injection inverts exactly the masked bits
  p_inject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flip_en |=> ((state_o ^ $past(state_o)) == $past(flip_mask) &&
                 err_o == $past(err_o)));
endmodule

// File: tb/tb_ohfsm_guard.sv
module tb_ohfsm_guard;
  localparam int N = 4;
  localparam int NVEC = 12;
  // {advance, expected state after the edge}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b1_0010, 5'b1_0100, 5'b0_0100, 5'b1_1000, 5'b1_0001, 5'b0_0001,
    5'b1_0010, 5'b1_0100, 5'b1_1000, 5'b0_1000, 5'b1_0001, 5'b1_0010
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic advance = 1'b0;
  logic flip_en = 1'b0;
  logic [N-1:0] flip_mask = '0;
  logic [N-1:0] state_o;
  logic err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ohfsm_guard #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .advance(advance), .flip_en(flip_en),
    .flip_mask(flip_mask), .state_o(state_o), .err_o(err_o)
  );

  task automatic check(input string req, input logic [N-1:0] exp_st, input logic exp_err);
    n_chk++;
    if (state_o !== exp_st || err_o !== exp_err) begin
      n_fail++;
      $display("FAIL %s: state=%b err=%b expected state=%b err=%b",
               req, state_o, err_o, exp_st, exp_err);
    end
  endtask

  // drive away from the edge, then sample 2 ns after the edge
  task automatic tick(input logic adv, input logic fen, input logic [N-1:0] m);
    advance = adv; flip_en = fen; flip_mask = m;
    @(posedge clk);
    #2;
    advance = 1'b0; flip_en = 1'b0; flip_mask = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(1'b1, 1'b0, '0);
    tick(1'b0, 1'b0, '0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2;
    // R1: reset state
    do_reset();
    check("R1 reset", 4'b0001, 1'b0);

    // R2/R3/R4: table of advance patterns
    for (int i = 0; i < NVEC; i++) begin
      tick(VEC[i][4], 1'b0, '0);
      check(VEC[i][4] ? "R3 step (R2 one-hot)" : "R4 hold (R2 one-hot)",
            VEC[i][3:0], 1'b0);
    end

    // R7/R8: single flip from each legal state
    for (int s = 0; s < N; s++) begin
      logic [N-1:0] legal, m;
      legal = 4'b0001 << s;
      m     = 4'b0001 << ((s + 1) % N);
      do_reset();
      for (int k = 0; k < s; k++) tick(1'b1, 1'b0, '0);
      check("R3 reach state", legal, 1'b0);
      tick(1'b1, 1'b1, m);
      check("R8 injected pattern", legal ^ m, 1'b0);
      tick(1'b1, 1'b0, '0);
      check("R7 single flip detected", 4'b0000, 1'b1);
    end

    // R5: multi-bit pattern 0101
    do_reset();
    tick(1'b0, 1'b1, 4'b0100);
    check("R8 inject 0101", 4'b0101, 1'b0);
    tick(1'b0, 1'b0, '0);
    check("R5 0101 to default", 4'b0000, 1'b1);

    // R6: sticky under advance, and after an injection back to one-hot
    for (int k = 0; k < 3; k++) begin
      tick(1'b1, 1'b0, '0);
      check("R6 stays parked", 4'b0000, 1'b1);
    end
    tick(1'b1, 1'b1, 4'b0010);
    check("R8 inject during error", 4'b0010, 1'b1);
    tick(1'b1, 1'b0, '0);
    check("R6 re-park after legal-looking value", 4'b0000, 1'b1);

    // R1: reset clears the error
    do_reset();
    check("R1 recovery by reset", 4'b0001, 1'b0);

    // R5: all-zero pattern is illegal
    tick(1'b0, 1'b1, 4'b0001);
    check("R8 inject 0000", 4'b0000, 1'b0);
    tick(1'b0, 1'b0, '0);
    check("R5 zero pattern flagged", 4'b0000, 1'b1);

    // R9: double flip onto another legal state goes unnoticed
    do_reset();
    tick(1'b0, 1'b1, 4'b0011);
    check("R9 double flip to S1", 4'b0010, 1'b0);
    tick(1'b1, 1'b0, '0);
    check("R9 continues from S1", 4'b0100, 1'b0);
    tick(1'b1, 1'b0, '0);
    check("R3 continues to S3", 4'b1000, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule